// File: doc/BRIEF.md
# Dual-Channel Serial Interrupt Status and Vector Unit

This block gathers the transmit and receive condition flags of two serial channels into one 8-bit interrupt status word. A mask register, written by the processor, selects which status bits may cause an interrupt. When the masked status changes from all-zero to non-zero, the block raises an interrupt request. The request stays high until the processor acknowledges it.

During an acknowledge cycle the block drives an 8-bit vector. If a request is pending, the vector is the processor-programmed value, and the request is withdrawn. If no request is pending, the vector is the fixed spurious-interrupt code. For each channel, a mode input chooses whether the receive source is "a character is waiting" or "the receive queue is full".

A small register window on the processor bus holds three registers. The status word is read-only at address 0. The mask is read/write at address 1. The vector is read/write at address 2. Address 3 reads as zero and ignores writes. Reads have no side effects.

Top module: `uart_irq_ctrl`

## Requirements
- R1: Status bit 0 equals channel 0 transmit-ready (`chanTxReady[0]`). Status bit 4 equals channel 1 transmit-ready (`chanTxReady[1]`).
- R2: Status bit 1 (channel 0) and status bit 5 (channel 1) are the receive source. The source is the channel's queue-full flag when its `chanFullMode` bit is 1, and its receive-ready flag when that bit is 0.
- R3: Status bits 2, 3, 6 and 7 always read as 0.
- R4: Bus address 1 reads back the mask register and address 2 reads back the vector register. A write with `busSel=1`, `busWr=1` updates the addressed register at the clock edge. Address 3 reads as 0x00, and a write to it changes no register.
- R5: After reset, the mask reads 0x00, the vector reads 0x0F and `intReq` is 0.
- R6: `intReq` goes high at the first clock edge after (status AND mask) changes from zero to non-zero. It stays high until acknowledged. A condition that stays non-zero does not raise it again after an acknowledge.
- R7: While `intAck` is high and a request is pending, `ackVector` equals the vector register. `intReq` is 0 after that clock edge, unless a new zero-to-non-zero change happens in the same cycle.
- R8: While `intAck` is high and no request is pending, `ackVector` is 0x18.
- R9: Status bits whose mask bit is 0 never raise `intReq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Register window access strobe |
| busWr | input | 1 | 1 = write, 0 = read |
| busAddr | input | 2 | Register address |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Read data, combinational, 0 when not reading |
| chanTxReady | input | 2 | Per-channel transmit-ready flag |
| chanRxReady | input | 2 | Per-channel character-waiting flag |
| chanFifoFull | input | 2 | Per-channel receive-queue-full flag |
| chanFullMode | input | 2 | Per-channel receive source select (1 = queue full) |
| intAck | input | 1 | Interrupt acknowledge cycle |
| intReq | output | 1 | Interrupt request |
| ackVector | output | 8 | Vector driven during acknowledge |

## Verification
Each channel flag is driven alone, and the status word is read. This shows that every flag reaches its own bit and no neighbour. The receive flags are then driven with both settings of the mode input, so a wrong source choice shows up as a missing or extra bit. The request path is exercised in several ways:
- with a condition whose mask bit is clear;
- by a mask write that exposes a condition that is already active, with the edge where the request appears pinned;
- with a condition held steady across an acknowledge.

These separate edge-triggered requests from level-triggered ones. Acknowledges both with and without a pending request tell the programmed vector apart from the spurious code.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [1:0] {
    RD_NONE   = 2'd0,
    RD_STATUS = 2'd1,
    RD_MASK   = 2'd2,
    RD_VECTOR = 2'd3
  } rdSel_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic   maskWr;
    logic   vecWr;
    rdSel_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/uart_irq_datapath.sv
module uart_irq_datapath
  import uart_irq_pkg::*;
#(
  parameter int NUM_CHAN     = 2,
  parameter int DATA_W       = 8,
  parameter int CHAN_STRIDE  = 4,
  parameter logic [DATA_W-1:0] RESET_VECTOR = 8'h0F
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobes_t        strobes,
  input  logic [DATA_W-1:0]   busWrData,
  input  logic [NUM_CHAN-1:0] chanTxReady,
  input  logic [NUM_CHAN-1:0] chanRxReady,
  input  logic [NUM_CHAN-1:0] chanFifoFull,
  input  logic [NUM_CHAN-1:0] chanFullMode,
  output logic [DATA_W-1:0]   statusVec,
  output logic [DATA_W-1:0]   maskReg,
  output logic [DATA_W-1:0]   vecReg,
  output logic [DATA_W-1:0]   rdData,
  output logic                anyMasked
);

  localparam int USED_W = NUM_CHAN * CHAN_STRIDE;
  localparam int PAD_W  = CHAN_STRIDE - 2;

  // Status assembly, one slice per channel
  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic rxSrc;
    assign rxSrc = chanFullMode[c] ? chanFifoFull[c] : chanRxReady[c];
    assign statusVec[c*CHAN_STRIDE +: CHAN_STRIDE] =
      {{PAD_W{1'b0}}, rxSrc, chanTxReady[c]};
  end

  if (USED_W < DATA_W) begin : g_pad
    assign statusVec[DATA_W-1:USED_W] = '0;
  end

  // Programmable registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      vecReg  <= RESET_VECTOR;
    end else begin
      if (strobes.maskWr) maskReg <= busWrData;
      if (strobes.vecWr)  vecReg  <= busWrData;
    end
  end

  assign anyMasked = |(statusVec & maskReg);

  // Read mux
  always_comb begin
    unique case (strobes.rdSel)
      RD_STATUS: rdData = statusVec;
      RD_MASK:   rdData = maskReg;
      RD_VECTOR: rdData = vecReg;
      default:   rdData = '0;
    endcase
  end

endmodule

// File: rtl/uart_irq_control.sv
module uart_irq_control
  import uart_irq_pkg::*;
#(
  parameter int ADDR_W = 2,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] STATUS_ADDR = 2'd0,
  parameter logic [ADDR_W-1:0] MASK_ADDR   = 2'd1,
  parameter logic [ADDR_W-1:0] VECTOR_ADDR = 2'd2,
  parameter logic [DATA_W-1:0] SPURIOUS_VECTOR = 8'h18
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWr,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              intAck,
  input  logic              anyMasked,
  input  logic [DATA_W-1:0] vecReg,
  output ctrlStrobes_t      strobes,
  output logic              intReq,
  output logic [DATA_W-1:0] ackVector
);

  logic prevMasked;
  logic pending;
  logic riseNow;

  // Bus decode
  always_comb begin
    strobes        = '0;
    strobes.rdSel  = RD_NONE;
    if (busSel) begin
      if (busWr) begin
        strobes.maskWr = (busAddr == MASK_ADDR);
        strobes.vecWr  = (busAddr == VECTOR_ADDR);
      end else begin
        if (busAddr == STATUS_ADDR)      strobes.rdSel = RD_STATUS;
        else if (busAddr == MASK_ADDR)   strobes.rdSel = RD_MASK;
        else if (busAddr == VECTOR_ADDR) strobes.rdSel = RD_VECTOR;
        else                             strobes.rdSel = RD_NONE;
      end
    end
  end

  assign riseNow = anyMasked && !prevMasked;

  // Edge-detected pending request
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevMasked <= 1'b0;
      pending    <= 1'b0;
    end else begin
      prevMasked <= anyMasked;
      if (riseNow)     pending <= 1'b1;
      else if (intAck) pending <= 1'b0;
    end
  end

  assign intReq    = pending;
  assign ackVector = pending ? vecReg : SPURIOUS_VECTOR;

endmodule

// File: rtl/uart_irq_ctrl.sv
module uart_irq_ctrl
  import uart_irq_pkg::*;
#(
  parameter int NUM_CHAN    = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int CHAN_STRIDE = 4,
  parameter logic [DATA_W-1:0] RESET_VECTOR    = 8'h0F,
  parameter logic [DATA_W-1:0] SPURIOUS_VECTOR = 8'h18
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                busSel,
  input  logic                busWr,
  input  logic [ADDR_W-1:0]   busAddr,
  input  logic [DATA_W-1:0]   busWrData,
  output logic [DATA_W-1:0]   busRdData,
  input  logic [NUM_CHAN-1:0] chanTxReady,
  input  logic [NUM_CHAN-1:0] chanRxReady,
  input  logic [NUM_CHAN-1:0] chanFifoFull,
  input  logic [NUM_CHAN-1:0] chanFullMode,
  input  logic                intAck,
  output logic                intReq,
  output logic [DATA_W-1:0]   ackVector
);

  ctrlStrobes_t      strobes;
  logic [DATA_W-1:0] statusVec;
  logic [DATA_W-1:0] maskReg;
  logic [DATA_W-1:0] vecReg;
  logic              anyMasked;

  uart_irq_control #(
    .ADDR_W          (ADDR_W),
    .DATA_W          (DATA_W),
    .SPURIOUS_VECTOR (SPURIOUS_VECTOR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busSel    (busSel),
    .busWr     (busWr),
    .busAddr   (busAddr),
    .intAck    (intAck),
    .anyMasked (anyMasked),
    .vecReg    (vecReg),
    .strobes   (strobes),
    .intReq    (intReq),
    .ackVector (ackVector)
  );

  uart_irq_datapath #(
    .NUM_CHAN     (NUM_CHAN),
    .DATA_W       (DATA_W),
    .CHAN_STRIDE  (CHAN_STRIDE),
    .RESET_VECTOR (RESET_VECTOR)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .busWrData    (busWrData),
    .chanTxReady  (chanTxReady),
    .chanRxReady  (chanRxReady),
    .chanFifoFull (chanFifoFull),
    .chanFullMode (chanFullMode),
    .statusVec    (statusVec),
    .maskReg      (maskReg),
    .vecReg       (vecReg),
    .rdData       (busRdData),
    .anyMasked    (anyMasked)
  );

endmodule

// File: rtl/uart_irq_checker.sv
module uart_irq_checker #(
  parameter int NUM_CHAN    = 2,
  parameter int DATA_W      = 8,
  parameter int ADDR_W      = 2,
  parameter int CHAN_STRIDE = 4,
  parameter logic [DATA_W-1:0] SPURIOUS_VECTOR = 8'h18
) (
  input logic                clk,
  input logic                rstN,
  input logic                busSel,
  input logic                busWr,
  input logic [ADDR_W-1:0]   busAddr,
  input logic [DATA_W-1:0]   busRdData,
  input logic [NUM_CHAN-1:0] chanTxReady,
  input logic                intAck,
  input logic                intReq,
  input logic [DATA_W-1:0]   ackVector,
  input logic                anyMasked,
  input logic [DATA_W-1:0]   vecReg
);

  logic statusRd;
  assign statusRd = busSel && !busWr && (busAddr == '0);

  a_r1_tx_bits: assert property (@(posedge clk) disable iff (!rstN)
    statusRd |-> (busRdData[0] == chanTxReady[0]) &&
                 (busRdData[CHAN_STRIDE] == chanTxReady[1]));

  a_r3_zero_bits: assert property (@(posedge clk) disable iff (!rstN)
    statusRd |-> (busRdData[3:2] == 2'b00) && (busRdData[7:6] == 2'b00));

  a_r6_rise_needs_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intReq) |-> $past(anyMasked));

  a_r7_ack_vector: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && intReq) |-> (ackVector == vecReg));

  a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !anyMasked) |=> !intReq);

  a_r8_spurious: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && !intReq) |-> (ackVector == SPURIOUS_VECTOR));

endmodule

bind uart_irq_ctrl uart_irq_checker #(
  .NUM_CHAN        (NUM_CHAN),
  .DATA_W          (DATA_W),
  .ADDR_W          (ADDR_W),
  .CHAN_STRIDE     (CHAN_STRIDE),
  .SPURIOUS_VECTOR (SPURIOUS_VECTOR)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busSel      (busSel),
  .busWr       (busWr),
  .busAddr     (busAddr),
  .busRdData   (busRdData),
  .chanTxReady (chanTxReady),
  .intAck      (intAck),
  .intReq      (intReq),
  .ackVector   (ackVector),
  .anyMasked   (anyMasked),
  .vecReg      (vecReg)
);

// File: tb/uart_irq_ctrl_tb.sv
module uart_irq_ctrl_tb_top;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busSel = 1'b0;
  logic       busWr = 1'b0;
  logic [1:0] busAddr = '0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [1:0] chanTxReady = '0;
  logic [1:0] chanRxReady = '0;
  logic [1:0] chanFifoFull = '0;
  logic [1:0] chanFullMode = '0;
  logic       intAck = 1'b0;
  logic       intReq;
  logic [7:0] ackVector;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_irq_ctrl dut_i (
    .clk          (clk),
    .rstN         (rstN),
    .busSel       (busSel),
    .busWr        (busWr),
    .busAddr      (busAddr),
    .busWrData    (busWrData),
    .busRdData    (busRdData),
    .chanTxReady  (chanTxReady),
    .chanRxReady  (chanRxReady),
    .chanFifoFull (chanFifoFull),
    .chanFullMode (chanFullMode),
    .intAck       (intAck),
    .intReq       (intReq),
    .ackVector    (ackVector)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%02h expected=0x%02h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a;
    #1 d = busRdData;
    busSel = 1'b0;
  endtask

  task automatic setFlags(input logic [1:0] tx, input logic [1:0] rx,
                          input logic [1:0] full, input logic [1:0] mode);
    @(negedge clk);
    chanTxReady = tx; chanRxReady = rx; chanFifoFull = full; chanFullMode = mode;
  endtask

  task automatic t_reset();
    logic [7:0] v;
    busRead(2'd1, v); chk("R5 mask after reset", v, 8'h00);
    busRead(2'd2, v); chk("R5 vector after reset", v, 8'h0F);
    chk("R5 intReq after reset", {7'd0, intReq}, 8'h00);
  endtask

  task automatic t_status();
    logic [7:0] v;
    setFlags(2'b01, 2'b00, 2'b00, 2'b00); busRead(2'd0, v); chk("R1 tx chan0", v, 8'h01);
    setFlags(2'b10, 2'b00, 2'b00, 2'b00); busRead(2'd0, v); chk("R1 tx chan1", v, 8'h10);
    setFlags(2'b00, 2'b01, 2'b00, 2'b00); busRead(2'd0, v); chk("R2 rx chan0 ready mode", v, 8'h02);
    setFlags(2'b00, 2'b01, 2'b00, 2'b01); busRead(2'd0, v); chk("R2 rx chan0 full mode not full", v, 8'h00);
    setFlags(2'b00, 2'b00, 2'b01, 2'b01); busRead(2'd0, v); chk("R2 rx chan0 full mode full", v, 8'h02);
    setFlags(2'b00, 2'b00, 2'b10, 2'b00); busRead(2'd0, v); chk("R2 rx chan1 ready mode ignores full", v, 8'h00);
    setFlags(2'b00, 2'b00, 2'b10, 2'b10); busRead(2'd0, v); chk("R2 rx chan1 full mode", v, 8'h20);
    setFlags(2'b11, 2'b11, 2'b11, 2'b11); busRead(2'd0, v); chk("R3 all flags unused bits zero", v, 8'h33);
    setFlags(2'b00, 2'b00, 2'b00, 2'b00);
  endtask

  task automatic t_regs();
    logic [7:0] v;
    busWrite(2'd1, 8'hA5); busRead(2'd1, v); chk("R4 mask readback", v, 8'hA5);
    busWrite(2'd2, 8'h40); busRead(2'd2, v); chk("R4 vector readback", v, 8'h40);
    busWrite(2'd3, 8'hFF); busRead(2'd3, v); chk("R4 addr3 reads zero", v, 8'h00);
    busRead(2'd1, v); chk("R4 addr3 write leaves mask", v, 8'hA5);
    busRead(2'd2, v); chk("R4 addr3 write leaves vector", v, 8'h40);
    busWrite(2'd1, 8'h00);
  endtask

  task automatic t_irq();
    // Masked-off condition
    setFlags(2'b01, 2'b00, 2'b00, 2'b00);
    repeat (3) @(negedge clk);
    chk("R9 unmasked bit no request", {7'd0, intReq}, 8'h00);
    busWrite(2'd1, 8'hEE);
    repeat (2) @(negedge clk);
    chk("R9 other mask bits no request", {7'd0, intReq}, 8'h00);
    // Expose the active condition
    busWrite(2'd1, 8'h01);
    chk("R6 not yet at write edge", {7'd0, intReq}, 8'h00);
    @(negedge clk);
    chk("R6 request one edge after exposure", {7'd0, intReq}, 8'h01);
    repeat (3) @(negedge clk);
    chk("R6 request held", {7'd0, intReq}, 8'h01);
    // Acknowledge
    intAck = 1'b1;
    #1 chk("R7 ack vector", ackVector, 8'h40);
    @(negedge clk); intAck = 1'b0;
    chk("R7 request cleared", {7'd0, intReq}, 8'h00);
    repeat (3) @(negedge clk);
    chk("R6 steady condition no re-request", {7'd0, intReq}, 8'h00);
    // Spurious
    intAck = 1'b1;
    #1 chk("R8 spurious vector", ackVector, 8'h18);
    @(negedge clk); intAck = 1'b0;
    // New edge on channel 1 receive in full mode
    busWrite(2'd1, 8'h20);
    setFlags(2'b00, 2'b00, 2'b00, 2'b10);
    @(negedge clk);
    chanFifoFull = 2'b10;
    chk("R6 before flag edge", {7'd0, intReq}, 8'h00);
    @(negedge clk);
    chk("R6 flag edge raises request", {7'd0, intReq}, 8'h01);
    intAck = 1'b1;
    #1 chk("R7 ack vector second", ackVector, 8'h40);
    @(negedge clk); intAck = 1'b0;
    chk("R7 cleared second", {7'd0, intReq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_status();
    t_regs();
    t_irq();
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule